// File: doc/BRIEF.md
# Secure-Filtered Interrupt State Bitmaps

This block keeps three state bits for every interrupt: enable, pending and active. Software reaches them through 32-bit windows on a small request/response bus. Each state has two windows. In the set window a 1 turns a bit on. In the clear window a 1 turns a bit off. Every access is tagged secure or non-secure.

Each interrupt also has a group bit and a 2-bit non-secure access level. From these the bank forms a per-bit permission mask. The mask decides which bits a non-secure access may see or change while security is in force.

External interrupt lines enter the bank directly. Each line is either edge-triggered or level-sensitive. A rising edge on an edge-triggered line latches pending. When pending is read, the live level of every level-sensitive line is merged into the result.

The request channel uses valid/ready and the response channel uses valid/ready. Back-pressure works as follows:
- A request is accepted on a clock edge where both `req_valid` and `req_ready` are high.
- `req_ready` is low only while a response is waiting and `rsp_ready` is low.
- A waiting response holds its data unchanged until it is taken.

Top module: `irq_state_bank`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. Every accepted request produces a response on the next cycle, and a write returns data 0. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` stay unchanged.
- R2: Word index `k` covers interrupts `32k` to `32k+31`, and bit `n` of the word is interrupt `32k+n`. Index 0 and every index at or above `NUM_IRQ/32` read as zero and ignore writes. Window codes:
  - 0 and 1: enable, set and clear.
  - 2 and 3: pending, set and clear.
  - 4 and 5: active, set and clear.
  - 6: group.
  - 7: trigger mode.
  - 8: access levels of bits 0-15.
  - 9: access levels of bits 16-31.
  - 10 to 15: read zero and ignore writes.
- R3: In a set window, each 1 in the write data sets the permitted bit. Each 0 leaves its bit unchanged.
- R4: In a clear window, each 1 in the write data clears the permitted bit. Each 0 leaves its bit unchanged.
- R5: A secure access, or any access while `cfg_ds` is 1, uses an all-ones mask. A non-secure access with `cfg_ds` 0 uses a mask equal to the group bits OR the bits its access level allows. Masked-out bits read as zero and ignore writes.
- R6: The access level of word bit `n` is held in bits `[2m+1:2m]` of window 8 (for `n<16`, with `m=n`) or window 9 (with `m=n-16`).
  - Setting pending, and reading the set-pending window, needs a level of at least 1.
  - Clearing pending, reading the clear-pending window, and reading either active window needs a level of at least 2.
  - Enable access, active writes and trigger access use only the group bits.
- R7: Reading either pending window returns the latched pending bit OR the registered input level of every interrupt whose trigger bit is 0. The result is then filtered by R5/R6.
- R8: Input line `irq_in[i]` drives interrupt `32+i`. The line is registered each cycle. If the registered value was 0 and the line is 1 while the trigger bit is 1, the pending bit is set. An unchanged level latches nothing. When a rising edge and a clear-pending write hit the same bit in the same cycle, the bit ends up set.
- R9: The group window can be read and written by a secure access or while `cfg_ds` is 1. The access-level windows can be read and written only by a secure access with `cfg_ds` 0. Any other access to these windows reads zero and is ignored.
- R10: In the trigger window, 1 means edge-triggered. Reads and writes of this window are filtered by the group-only mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ds | input | 1 | 1 = security disabled (all-ones masks) |
| irq_in | input | NUM_IRQ-32 | Interrupt lines; bit i is interrupt 32+i |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| req_win | input | 4 | Window code |
| req_index | input | IDX_W | Word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes) |

## Verification
The following properties are checked on every cycle:
- a response is held while it is back-pressured;
- word 0 reads as zero;
- a set write never clears an enable bit;
- a clear write never sets an enable bit;
- a non-secure enable write cannot change bits outside the group;
- a non-secure write cannot change the group bits.

Some behaviour can be shown only by the bench's scenarios:
- the graded access levels giving different views of the same pending and active bits;
- the merge of live levels into pending read-back;
- edge latching that ignores a held level;
- the edge winning over a same-cycle clear;
- the effect of `cfg_ds` on permissions.

// File: rtl/irqbm_pkg.sv
package irqbm_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [3:0] {
    WIN_SET_EN   = 4'd0,
    WIN_CLR_EN   = 4'd1,
    WIN_SET_PEND = 4'd2,
    WIN_CLR_PEND = 4'd3,
    WIN_SET_ACT  = 4'd4,
    WIN_CLR_ACT  = 4'd5,
    WIN_GROUP    = 4'd6,
    WIN_TRIG     = 4'd7,
    WIN_ACC_LO   = 4'd8,
    WIN_ACC_HI   = 4'd9
  } win_e;

  // minimum access level a mask variant demands (0 = group term only)
  typedef enum logic [1:0] {
    GATE_GROUP = 2'd0,
    GATE_GE1   = 2'd1,
    GATE_GE2   = 2'd2
  } gate_e;

endpackage

// File: rtl/irqbm_perm_mask.sv
module irqbm_perm_mask
  import irqbm_pkg::*;
#(
  parameter gate_e GATE = GATE_GROUP
) (
  input  logic [WORD_W-1:0]   grp_i,
  input  logic [2*WORD_W-1:0] acc_i,
  input  logic                secure_i,
  input  logic                ds_i,
  output logic [WORD_W-1:0]   mask_o
);

  localparam logic [1:0] THR = GATE;

  logic [WORD_W-1:0] acc_ok;

  // one comparator per interrupt bit against the variant's threshold
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign acc_ok[b] = (THR != 2'd0) && (acc_i[2*b +: 2] >= THR);
  end

  always_comb begin
    if (secure_i || ds_i) mask_o = '1;
    else                  mask_o = grp_i | acc_ok;
  end

endmodule

// File: rtl/irqbm_word.sv
module irqbm_word
  import irqbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  win_e              win_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              secure_i,
  input  logic              ds_i,
  input  logic [WORD_W-1:0] line_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic [WORD_W-1:0]   en_q, pend_q, act_q, grp_q, trig_q, lvl_q;
  logic [2*WORD_W-1:0] acc_q;
  logic [WORD_W-1:0]   en_d, pend_d, act_d, grp_d, trig_d;
  logic [2*WORD_W-1:0] acc_d;
  logic [WORD_W-1:0]   m_grp, m_ge1, m_ge2;
  logic [WORD_W-1:0]   rise, pend_view;
  logic                cfg_ok, acc_win_ok;

  irqbm_perm_mask #(.GATE(GATE_GROUP)) u_m_grp (
    .grp_i(grp_q), .acc_i(acc_q), .secure_i(secure_i), .ds_i(ds_i), .mask_o(m_grp));
  irqbm_perm_mask #(.GATE(GATE_GE1)) u_m_ge1 (
    .grp_i(grp_q), .acc_i(acc_q), .secure_i(secure_i), .ds_i(ds_i), .mask_o(m_ge1));
  irqbm_perm_mask #(.GATE(GATE_GE2)) u_m_ge2 (
    .grp_i(grp_q), .acc_i(acc_q), .secure_i(secure_i), .ds_i(ds_i), .mask_o(m_ge2));

  assign cfg_ok     = secure_i || ds_i;
  assign acc_win_ok = secure_i && !ds_i;
  assign rise       = line_i & ~lvl_q & trig_q;
  assign pend_view  = pend_q | (lvl_q & ~trig_q);

  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    act_d  = act_q;
    grp_d  = grp_q;
    trig_d = trig_q;
    acc_d  = acc_q;
    if (wr_i) begin
      unique case (win_i)
        WIN_SET_EN:   en_d   = en_q | (wdata_i & m_grp);
        WIN_CLR_EN:   en_d   = en_q & ~(wdata_i & m_grp);
        WIN_SET_PEND: pend_d = pend_q | (wdata_i & m_ge1);
        WIN_CLR_PEND: pend_d = pend_q & ~(wdata_i & m_ge2);
        WIN_SET_ACT:  act_d  = act_q | (wdata_i & m_grp);
        WIN_CLR_ACT:  act_d  = act_q & ~(wdata_i & m_grp);
        WIN_GROUP:    if (cfg_ok) grp_d = wdata_i;
        WIN_TRIG:     trig_d = (trig_q & ~m_grp) | (wdata_i & m_grp);
        WIN_ACC_LO:   if (acc_win_ok) acc_d[WORD_W-1:0] = wdata_i;
        WIN_ACC_HI:   if (acc_win_ok) acc_d[2*WORD_W-1:WORD_W] = wdata_i;
        default: ;
      endcase
    end
    // an input edge lands after any software clear of the same cycle
    pend_d = pend_d | rise;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
      grp_q  <= '0;
      trig_q <= '0;
      acc_q  <= '0;
      lvl_q  <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      grp_q  <= grp_d;
      trig_q <= trig_d;
      acc_q  <= acc_d;
      lvl_q  <= line_i;
    end
  end

  always_comb begin
    unique case (win_i)
      WIN_SET_EN, WIN_CLR_EN:   rdata_o = en_q & m_grp;
      WIN_SET_PEND:             rdata_o = pend_view & m_ge1;
      WIN_CLR_PEND:             rdata_o = pend_view & m_ge2;
      WIN_SET_ACT, WIN_CLR_ACT: rdata_o = act_q & m_ge2;
      WIN_GROUP:                rdata_o = cfg_ok ? grp_q : '0;
      WIN_TRIG:                 rdata_o = trig_q & m_grp;
      WIN_ACC_LO:               rdata_o = acc_win_ok ? acc_q[WORD_W-1:0] : '0;
      WIN_ACC_HI:               rdata_o = acc_win_ok ? acc_q[2*WORD_W-1:WORD_W] : '0;
      default:                  rdata_o = '0;
    endcase
  end

  // R3: a set-enable write never drops an enable bit
  a_r3_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && win_i == WIN_SET_EN) |=> (($past(en_q) & ~en_q) == '0));

  // R4: a clear-enable write never raises an enable bit
  a_r4_clr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && win_i == WIN_CLR_EN) |=> ((en_q & ~$past(en_q)) == '0));

  // R5: gated non-secure enable writes stay inside the group bits
  a_r5_ns_en_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !secure_i && !ds_i && (win_i == WIN_SET_EN || win_i == WIN_CLR_EN))
    |=> (((en_q ^ $past(en_q)) & ~$past(grp_q)) == '0));

  // R9: gated non-secure writes cannot alter the group bits
  a_r9_group_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !secure_i && !ds_i) |=> $stable(grp_q));

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irqbm_pkg::*;
#(
  parameter int NUM_IRQ = 128,
  parameter int IDX_W   = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_ds,
  input  logic [NUM_IRQ-33:0]    irq_in,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_secure,
  input  logic [3:0]             req_win,
  input  logic [IDX_W-1:0]       req_index,
  input  logic [WORD_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [WORD_W-1:0]      rsp_rdata
);

  localparam int NUM_WORDS = NUM_IRQ / WORD_W;

  logic              accept;
  win_e              win;
  logic [WORD_W-1:0] word_rd [NUM_WORDS];
  logic [WORD_W-1:0] rd_sel;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign win       = win_e'(req_win);

  // word 0 holds the internal interrupts: no storage, reads zero
  assign word_rd[0] = '0;

  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
    logic wr_w;
    assign wr_w = accept && req_write && (req_index == IDX_W'(w));
    irqbm_word u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_w),
      .win_i    (win),
      .wdata_i  (req_wdata),
      .secure_i (req_secure),
      .ds_i     (cfg_ds),
      .line_i   (irq_in[(w-1)*WORD_W +: WORD_W]),
      .rdata_o  (word_rd[w])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int w = 1; w < NUM_WORDS; w++) begin
      if (req_index == IDX_W'(w)) rd_sel = rd_sel | word_rd[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_sel;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1: a response that is not taken stays put
  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R2: the internal word always reads as zero
  a_r2_word0_raz: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && req_index == '0) |=> (rsp_rdata == '0));

endmodule

// File: tb/irq_state_bank_tb.sv
`timescale 1ns/1ps
module irq_state_bank_tb;

  localparam int NUM_IRQ = 128;
  localparam int IDX_W   = 5;

  typedef struct packed {
    logic        wr;
    logic        sec;
    logic [3:0]  win;
    logic [4:0]  idx;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  // walked from reset with cfg_ds = 0 and all lines low
  localparam int NV = 39;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,4'd6,5'd1,32'h0000FFFF,32'h0,4'd9},
    '{1'b0,1'b1,4'd6,5'd1,32'h0,32'h0000FFFF,4'd9},  // R9 secure group read
    '{1'b0,1'b0,4'd6,5'd1,32'h0,32'h0,4'd9},         // R9 NS group RAZ
    '{1'b1,1'b0,4'd0,5'd1,32'hFFFFFFFF,32'h0,4'd5},
    '{1'b0,1'b1,4'd0,5'd1,32'h0,32'h0000FFFF,4'd5},  // R5 NS set limited to group
    '{1'b1,1'b1,4'd0,5'd1,32'hFF000000,32'h0,4'd3},
    '{1'b0,1'b0,4'd1,5'd1,32'h0,32'h0000FFFF,4'd5},  // R5 NS read masked
    '{1'b0,1'b1,4'd1,5'd1,32'h0,32'hFF00FFFF,4'd3},  // R3
    '{1'b1,1'b0,4'd1,5'd1,32'h0F0F000F,32'h0,4'd4},
    '{1'b0,1'b1,4'd0,5'd1,32'h0,32'hFF00FFF0,4'd4},  // R4
    '{1'b1,1'b1,4'd0,5'd1,32'h0,32'h0,4'd3},
    '{1'b0,1'b1,4'd0,5'd1,32'h0,32'hFF00FFF0,4'd3},  // R3 zeros ignored
    '{1'b1,1'b1,4'd9,5'd1,32'h00000039,32'h0,4'd9},
    '{1'b0,1'b1,4'd9,5'd1,32'h0,32'h00000039,4'd9},
    '{1'b0,1'b0,4'd9,5'd1,32'h0,32'h0,4'd9},
    '{1'b1,1'b0,4'd2,5'd1,32'hFFFF0000,32'h0,4'd6},
    '{1'b0,1'b1,4'd2,5'd1,32'h0,32'h00070000,4'd6},  // R6 levels >=1 set
    '{1'b0,1'b0,4'd2,5'd1,32'h0,32'h00070000,4'd6},
    '{1'b0,1'b0,4'd3,5'd1,32'h0,32'h00060000,4'd6},  // R6 clear view >=2
    '{1'b1,1'b0,4'd3,5'd1,32'hFFFFFFFF,32'h0,4'd6},
    '{1'b0,1'b1,4'd2,5'd1,32'h0,32'h00010000,4'd6},  // R6 level 1 cannot clear
    '{1'b1,1'b0,4'd4,5'd1,32'hFFFFFFFF,32'h0,4'd6},
    '{1'b0,1'b1,4'd4,5'd1,32'h0,32'h0000FFFF,4'd6},  // R6 active write group only
    '{1'b1,1'b1,4'd4,5'd1,32'h00070000,32'h0,4'd3},
    '{1'b0,1'b0,4'd5,5'd1,32'h0,32'h0006FFFF,4'd6},  // R6 active read >=2
    '{1'b0,1'b1,4'd5,5'd1,32'h0,32'h0007FFFF,4'd3},
    '{1'b1,1'b1,4'd0,5'd0,32'hFFFFFFFF,32'h0,4'd2},
    '{1'b0,1'b1,4'd0,5'd0,32'h0,32'h0,4'd2},         // R2 word 0
    '{1'b1,1'b1,4'd0,5'd4,32'hFFFFFFFF,32'h0,4'd2},
    '{1'b0,1'b1,4'd0,5'd4,32'h0,32'h0,4'd2},         // R2 out of range
    '{1'b1,1'b1,4'd0,5'd2,32'h80000001,32'h0,4'd2},
    '{1'b0,1'b1,4'd0,5'd2,32'h0,32'h80000001,4'd2},  // R2 bit mapping
    '{1'b1,1'b1,4'd7,5'd2,32'h000000F0,32'h0,4'd10},
    '{1'b0,1'b1,4'd7,5'd2,32'h0,32'h000000F0,4'd10}, // R10
    '{1'b1,1'b0,4'd7,5'd2,32'hFFFFFFFF,32'h0,4'd10},
    '{1'b0,1'b1,4'd7,5'd2,32'h0,32'h000000F0,4'd10},
    '{1'b0,1'b0,4'd7,5'd2,32'h0,32'h0,4'd10},
    '{1'b1,1'b1,4'd5,5'd1,32'h0000FFFF,32'h0,4'd4},
    '{1'b0,1'b1,4'd4,5'd1,32'h0,32'h00070000,4'd4}   // R4 active clear
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_ds = 1'b0;
  logic [NUM_IRQ-33:0] irq_in = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic              req_secure = 1'b0;
  logic [3:0]        req_win = '0;
  logic [IDX_W-1:0]  req_index = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [31:0]       rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_state_bank #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ds(cfg_ds), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_secure(req_secure), .req_win(req_win), .req_index(req_index),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic sec, input logic [3:0] win,
                      input logic [4:0] idx, input logic [31:0] wd,
                      output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_secure = sec;
    req_win = win; req_index = idx; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1 reset req_ready", {31'b0, req_ready}, 32'h1);
    xfer(1'b0, 1'b1, 4'd0, 5'd1, 32'h0, rd);
    chk("R3 reset enable", rd, 32'h0);
    xfer(1'b1, 1'b1, 4'd0, 5'd1, 32'h0, rd);
    chk("R1 write returns zero", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].sec, VECS[i].win, VECS[i].idx, VECS[i].wd, rd);
      if (!VECS[i].wr) chk($sformatf("R%0d vec %0d", VECS[i].rq, i), rd, VECS[i].exp);
    end
    xfer(1'b0, 1'b1, 4'd12, 5'd1, 32'h0, rd);
    chk("R2 unused window", rd, 32'h0);

    // R7 and R8 on word 2: bit 4 edge (line 36), bit 8 level (line 40)
    @(negedge clk); irq_in[36] = 1'b1; irq_in[40] = 1'b1;
    xfer(1'b0, 1'b1, 4'd2, 5'd2, 32'h0, rd);
    chk("R8 edge latched plus R7 level", rd, 32'h00000110);
    @(negedge clk); irq_in[36] = 1'b0; irq_in[40] = 1'b0;
    xfer(1'b0, 1'b1, 4'd2, 5'd2, 32'h0, rd);
    chk("R7 level gone, R8 latch kept", rd, 32'h00000010);
    xfer(1'b1, 1'b1, 4'd3, 5'd2, 32'h10, rd);
    xfer(1'b0, 1'b1, 4'd2, 5'd2, 32'h0, rd);
    chk("R4 pending cleared", rd, 32'h0);
    @(negedge clk); irq_in[36] = 1'b1;
    xfer(1'b1, 1'b1, 4'd3, 5'd2, 32'h10, rd);
    repeat (3) @(negedge clk);
    xfer(1'b0, 1'b1, 4'd2, 5'd2, 32'h0, rd);
    chk("R8 held level does not relatch", rd, 32'h0);
    @(negedge clk); irq_in[36] = 1'b0;
    @(negedge clk);
    // rising edge and clear of the same bit in one cycle
    irq_in[36] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_secure = 1'b1;
    req_win = 4'd3; req_index = 5'd2; req_wdata = 32'h10;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    xfer(1'b0, 1'b1, 4'd2, 5'd2, 32'h0, rd);
    chk("R8 edge beats clear", rd, 32'h00000010);
    xfer(1'b1, 1'b1, 4'd3, 5'd2, 32'h10, rd);
    @(negedge clk); irq_in[36] = 1'b0; irq_in[40] = 1'b1;
    xfer(1'b0, 1'b1, 4'd3, 5'd2, 32'h0, rd);
    chk("R7 live level in clear-pending view", rd, 32'h00000100);
    @(negedge clk); irq_in[40] = 1'b0;

    // cfg_ds = 1: all-ones masks, access-level windows locked
    @(negedge clk); cfg_ds = 1'b1;
    xfer(1'b0, 1'b0, 4'd6, 5'd1, 32'h0, rd);
    chk("R9 NS group read with ds", rd, 32'h0000FFFF);
    xfer(1'b1, 1'b1, 4'd9, 5'd1, 32'hFFFFFFFF, rd);
    xfer(1'b0, 1'b1, 4'd9, 5'd1, 32'h0, rd);
    chk("R9 access level RAZ with ds", rd, 32'h0);
    xfer(1'b1, 1'b0, 4'd1, 5'd1, 32'hFFFFFFFF, rd);
    xfer(1'b0, 1'b0, 4'd0, 5'd1, 32'h0, rd);
    chk("R5 NS all-ones mask with ds", rd, 32'h0);
    @(negedge clk); cfg_ds = 1'b0;
    xfer(1'b0, 1'b1, 4'd9, 5'd1, 32'h0, rd);
    chk("R9 access level write ignored with ds", rd, 32'h00000039);

    // R1 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_secure = 1'b1;
    req_win = 4'd0; req_index = 5'd2; req_wdata = '0;
    @(posedge clk);
    @(negedge clk);
    req_win = 4'd7;
    chk("R1 held valid", {31'b0, rsp_valid}, 32'h1);
    chk("R1 ready low", {31'b0, req_ready}, 32'h0);
    chk("R1 first data", rsp_rdata, 32'h80000001);
    @(negedge clk);
    chk("R1 data stable", rsp_rdata, 32'h80000001);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 second data", rsp_rdata, 32'h000000F0);
    @(negedge clk);
    chk("R1 drained", {31'b0, rsp_valid}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule